// File: doc/BRIEF.md
# Shared-bus register transfer datapath

This block is a 16-bit datapath. Six registers and a word-addressed memory exchange data over one shared bus, so no register has a direct wire to any other. A 3-bit source select picks the single source that drives the bus in a cycle. Every destination takes its data from that bus. A register with its load enable high captures the bus on the next rising clock edge. The memory stores the bus word when its write strobe is high.

The memory holds 4096 words. The address register selects the word that is read or written. Reads are combinational, so a memory-to-register move takes one cycle. At power-up the memory holds a fixed computed image, which lets a controller move data into the registers without an external data port. A sequencer outside the block drives every select, strobe and enable.

Top module: `shared_bus_datapath`

## Requirements
- R1: The bus source is chosen by `sel`. Code 0 gives all zeros, 1 the address register, 2 the program counter, 3 the data register, 4 the accumulator, 5 the instruction register and 6 the temporary register. Code 7 gives the memory word at the address register while `mem_rd` is 1.
- R2: With `sel` = 7 and `mem_rd` = 0 the bus is zero. With any other `sel`, `mem_rd` has no effect on the bus.
- R3: A register whose load enable is 1 holds the bus value after the next rising edge. A register whose load enable is 0 keeps its value.
- R4: The address register and the program counter are 12 bits. On the bus they are zero-extended to 16 bits. When one of them loads, it takes bus bits 11..0.
- R5: When `mem_wr` is 1, the bus word is stored at the rising edge into the word addressed by the address register as it stood before that edge. This holds even when the address register loads at the same edge.
- R6: A memory read with a register load completes in one cycle. The destination holds the addressed word after that edge.
- R7: While `rst` is 1 at a rising edge, all six registers clear to zero. Memory contents are kept.
- R8: At power-up, memory word i holds (i × 0x2F1D) XOR 0xA5C3, truncated to 16 bits.
- R9: Several registers may load the same bus value at one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the registers |
| sel | input | 3 | Bus source select |
| mem_rd | input | 1 | Memory read strobe, used with sel = 7 |
| mem_wr | input | 1 | Memory write strobe |
| ld_ar | input | 1 | Address register load enable |
| ld_pc | input | 1 | Program counter load enable |
| ld_dr | input | 1 | Data register load enable |
| ld_ac | input | 1 | Accumulator load enable |
| ld_ir | input | 1 | Instruction register load enable |
| ld_tr | input | 1 | Temporary register load enable |
| bus_out | output | 16 | Current shared bus value |
| ar_q | output | 12 | Address register |
| pc_q | output | 12 | Program counter |
| dr_q | output | 16 | Data register |
| ac_q | output | 16 | Accumulator |
| ir_q | output | 16 | Instruction register |
| tr_q | output | 16 | Temporary register |

## Verification
A memory write and an address register load can fall in the same cycle. When they do, the write must use the old address while the address register picks up the new one. A directed step drives the program counter onto the bus with both `mem_wr` and `ld_ar` high. It then restores the old address and reads that word back, which must equal the written program counter value. The randomized phase also raises these strobes together often, and a behavioural model judges every cycle's bus and register values.

// File: rtl/shared_bus_datapath.sv
module shared_bus_datapath #(
  parameter int              DATA_W    = 16,
  parameter int              ADDR_W    = 12,
  parameter logic [15:0]     INIT_MULT = 16'h2F1D,
  parameter logic [15:0]     INIT_XOR  = 16'hA5C3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        sel,
  input  logic              mem_rd,
  input  logic              mem_wr,
  input  logic              ld_ar,
  input  logic              ld_pc,
  input  logic              ld_dr,
  input  logic              ld_ac,
  input  logic              ld_ir,
  input  logic              ld_tr,
  output logic [DATA_W-1:0] bus_out,
  output logic [ADDR_W-1:0] ar_q,
  output logic [ADDR_W-1:0] pc_q,
  output logic [DATA_W-1:0] dr_q,
  output logic [DATA_W-1:0] ac_q,
  output logic [DATA_W-1:0] ir_q,
  output logic [DATA_W-1:0] tr_q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] mem_word;

  initial begin
    for (int i = 0; i < DEPTH; i++)
      mem[i] = DATA_W'(DATA_W'(i) * DATA_W'(INIT_MULT) ^ DATA_W'(INIT_XOR));
  end

  assign mem_word = mem[ar_q];

  always_comb begin
    case (sel)
      3'd1:    bus_out = DATA_W'(ar_q);
      3'd2:    bus_out = DATA_W'(pc_q);
      3'd3:    bus_out = dr_q;
      3'd4:    bus_out = ac_q;
      3'd5:    bus_out = ir_q;
      3'd6:    bus_out = tr_q;
      3'd7:    bus_out = mem_rd ? mem_word : '0;
      default: bus_out = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ar_q <= '0;
      pc_q <= '0;
      dr_q <= '0;
      ac_q <= '0;
      ir_q <= '0;
      tr_q <= '0;
    end else begin
      if (ld_ar) ar_q <= bus_out[ADDR_W-1:0];
      if (ld_pc) pc_q <= bus_out[ADDR_W-1:0];
      if (ld_dr) dr_q <= bus_out;
      if (ld_ac) ac_q <= bus_out;
      if (ld_ir) ir_q <= bus_out;
      if (ld_tr) tr_q <= bus_out;
    end
  end

  always_ff @(posedge clk) begin
    if (mem_wr) mem[ar_q] <= bus_out;
  end

  a_r3_load: assert property (@(posedge clk) disable iff (rst)
    ld_ac |=> ac_q == $past(bus_out));
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !ld_ir |=> $stable(ir_q));
  a_r2_idle: assert property (@(posedge clk) disable iff (rst)
    (sel == 3'd7 && !mem_rd) |-> bus_out == '0);
  a_r2_rd_ignored: assert property (@(posedge clk) disable iff (rst)
    (sel == 3'd3) |-> bus_out == dr_q);
  a_r4_zext: assert property (@(posedge clk) disable iff (rst)
    (sel == 3'd1 || sel == 3'd2) |-> bus_out[DATA_W-1:ADDR_W] == '0);
  a_r6_read: assert property (@(posedge clk) disable iff (rst)
    (sel == 3'd7 && mem_rd && ld_dr) |=> dr_q == $past(mem_word));
  a_r7_clear: assert property (@(posedge clk)
    rst |=> (ar_q == '0 && pc_q == '0 && ac_q == '0 && tr_q == '0));
endmodule

// File: tb/sim_shared_bus_datapath.sv
module sim_shared_bus_datapath;
  logic clk = 0;
  logic rst, mem_rd, mem_wr, ld_ar, ld_pc, ld_dr, ld_ac, ld_ir, ld_tr;
  logic [2:0] sel;
  logic [15:0] bus_out, dr_q, ac_q, ir_q, tr_q;
  logic [11:0] ar_q, pc_q;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [15:0] mm [4096];
  logic [11:0] m_ar, m_pc;
  logic [15:0] m_dr, m_ac, m_ir, m_tr;

  always #10 clk = ~clk;

  shared_bus_datapath u0 (
    .clk(clk), .rst(rst), .sel(sel), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .ld_ar(ld_ar), .ld_pc(ld_pc), .ld_dr(ld_dr), .ld_ac(ld_ac),
    .ld_ir(ld_ir), .ld_tr(ld_tr), .bus_out(bus_out), .ar_q(ar_q),
    .pc_q(pc_q), .dr_q(dr_q), .ac_q(ac_q), .ir_q(ir_q), .tr_q(tr_q));

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] model_bus(logic [2:0] s, logic rd);
    case (s)
      3'd1: return {4'h0, m_ar};
      3'd2: return {4'h0, m_pc};
      3'd3: return m_dr;
      3'd4: return m_ac;
      3'd5: return m_ir;
      3'd6: return m_tr;
      3'd7: return rd ? mm[m_ar] : 16'h0;
      default: return 16'h0;
    endcase
  endfunction

  // lds order: {tr, ir, ac, dr, pc, ar}
  task automatic step(string tag, logic r, logic [2:0] s, logic [5:0] lds, logic rd, logic wr);
    logic [15:0] b;
    rst = r; sel = s; mem_rd = rd; mem_wr = wr;
    {ld_tr, ld_ir, ld_ac, ld_dr, ld_pc, ld_ar} = lds;
    #1;
    b = model_bus(s, rd);
    chk(tag, "bus", bus_out, b);
    @(posedge clk);
    if (wr) mm[m_ar] = b;
    if (r) begin
      m_ar = 0; m_pc = 0; m_dr = 0; m_ac = 0; m_ir = 0; m_tr = 0;
    end else begin
      if (lds[0]) m_ar = b[11:0];
      if (lds[1]) m_pc = b[11:0];
      if (lds[2]) m_dr = b;
      if (lds[3]) m_ac = b;
      if (lds[4]) m_ir = b;
      if (lds[5]) m_tr = b;
    end
    @(negedge clk);
    chk(tag, "ar", {4'h0, ar_q}, {4'h0, m_ar});
    chk(tag, "pc", {4'h0, pc_q}, {4'h0, m_pc});
    chk(tag, "dr", dr_q, m_dr);
    chk(tag, "ac", ac_q, m_ac);
    chk(tag, "ir", ir_q, m_ir);
    chk(tag, "tr", tr_q, m_tr);
  endtask

  initial begin
    #3000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) begin
      logic [15:0] a;
      a = 16'(i);
      mm[i] = a * 16'h2F1D ^ 16'hA5C3;
    end
    m_ar = 0; m_pc = 0; m_dr = 0; m_ac = 0; m_ir = 0; m_tr = 0;
    rst = 1; sel = 0; mem_rd = 0; mem_wr = 0;
    {ld_tr, ld_ir, ld_ac, ld_dr, ld_pc, ld_ar} = '0;
    @(negedge clk);
    step("R7", 1, 3'd0, 6'b0, 0, 0);
    step("R1", 0, 3'd0, 6'b0, 1, 0);
    step("R2", 0, 3'd7, 6'b000100, 0, 0);
    step("R8", 0, 3'd7, 6'b000100, 1, 0);
    step("R6", 0, 3'd7, 6'b000100, 1, 0);
    step("R4", 0, 3'd3, 6'b000001, 0, 0);
    step("R9", 0, 3'd7, 6'b111000, 1, 0);
    step("R4", 0, 3'd1, 6'b000000, 1, 0);
    step("R4", 0, 3'd4, 6'b000010, 0, 0);
    step("R2", 0, 3'd3, 6'b100000, 1, 0);
    step("R3", 0, 3'd5, 6'b000000, 0, 0);
    step("R5", 0, 3'd3, 6'b000001, 0, 0);
    step("R5", 0, 3'd2, 6'b000001, 0, 1);
    step("R5", 0, 3'd3, 6'b000001, 0, 0);
    step("R5", 0, 3'd7, 6'b001000, 1, 0);
    step("R3", 0, 3'd6, 6'b010000, 0, 0);
    step("R7", 1, 3'd0, 6'b0, 0, 0);
    step("R7", 0, 3'd7, 6'b000100, 1, 0);
    for (int n = 0; n < 2000; n++) begin
      logic r, rd, wr;
      logic [2:0] s;
      logic [5:0] l;
      r = ($urandom_range(0, 49) == 0);
      s = 3'($urandom_range(0, 7));
      l = 6'($urandom);
      rd = 1'($urandom);
      wr = r ? 1'b0 : ($urandom_range(0, 3) == 0);
      step("R3", r, s, l, rd, wr);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule